// File: doc/BRIEF.md
# Burst Cycle Type Protocol Checker

This block is a passive monitor placed beside a bus master that uses classic cycles with a three-bit cycle type tag. It samples the master's cycle-active, write-enable, acknowledge and cycle type lines and never drives any of them. Every clock edge on which the acknowledge is high is one completed beat. The block sorts that beat into one of four kinds: a single read, a single write, a burst beat or the closing beat of a burst.

Write transfers are counted as the receive direction and read transfers as the transmit direction. Four saturating counters hold the completed single and burst transfers for each direction. A burst must hold exactly `BURST_LEN` beats: `BURST_LEN-1` incrementing beats followed by one end-of-burst beat. A single access must never appear between them. The first breach of these rules raises a sticky error flag and records a two-bit cause. There is no data stream to carry, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `burst_cti_monitor`

## Requirements
- R1: A synchronous active-high `rst` clears all four counters, `err_flag` and `err_cause`, and discards any open burst.
- R2: An acknowledged beat with `bus_cyc`=1 and `bus_cti`=3'b000 while no burst is open increments `single_wr_count` if `bus_we`=1 and `single_rd_count` if `bus_we`=0. The new value shows after that edge.
- R3: On an edge where `bus_ack`=0, no counter, error output or burst state changes, whatever `bus_cyc`, `bus_we` and `bus_cti` carry.
- R4: A burst is `BURST_LEN-1` acknowledged beats with `bus_cti`=3'b010, then one with `bus_cti`=3'b111, all with `bus_cyc`=1. It increments `burst_wr_count` or `burst_rd_count` by one, chosen by `bus_we` on the closing beat, and the burst closes. Edges with `bus_ack`=0 may fall between the beats.
- R5: A single (3'b000) beat that arrives after at least one 3'b010 beat of an open burst is not counted and reports cause 1 (single inside burst).
- R6: A 3'b111 beat that arrives with fewer than `BURST_LEN-1` beats counted, or a 3'b010 beat that arrives with `BURST_LEN-1` already counted, reports cause 2 (bad burst length). No burst is counted and the burst closes.
- R7: Any other acknowledged beat reports cause 3 (unknown type or sequence). This covers `bus_cyc`=0, and `bus_cti` values 3'b001, 3'b011, 3'b100, 3'b101 and 3'b110.
- R8: `err_flag` stays high until reset. `err_cause` keeps the code of the first error and ignores later ones. Legal beats after an error are still counted. The cause codes are 0 = none, 1 = single inside burst, 2 = bad length, 3 = unknown.
- R9: Each `CNT_W`-bit counter stops at 2^CNT_W-1 and holds that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cyc | input | 1 | Cycle-active line of the observed master |
| bus_we | input | 1 | Write enable of the observed master |
| bus_ack | input | 1 | Acknowledge returned to the master |
| bus_cti | input | 3 | Cycle type tag of the observed master |
| single_rd_count | output | CNT_W | Completed single reads (transmit) |
| single_wr_count | output | CNT_W | Completed single writes (receive) |
| burst_rd_count | output | CNT_W | Completed read bursts (transmit) |
| burst_wr_count | output | CNT_W | Completed write bursts (receive) |
| err_flag | output | 1 | Sticky protocol error |
| err_cause | output | 2 | Cause of the first error |

## Verification
The assertions assume that the observed lines are synchronous to `clk` and hold a known value on each edge. They also assume that `BURST_LEN` is at least 2, so that a burst always contains at least one incrementing beat before its closing beat. The stimulus changes the inputs only on the falling edge and always drives 0 or 1. It drives `bus_ack` low between test phases, so that a phase always starts from an idle edge. Error scenarios run after a reset, so that each new cause can be observed rather than hidden behind an earlier sticky one.

// File: rtl/cti_mon_pkg.sv
package cti_mon_pkg;

  localparam logic [2:0] CTI_CLASSIC = 3'b000;
  localparam logic [2:0] CTI_INCR    = 3'b010;
  localparam logic [2:0] CTI_LAST    = 3'b111;

  localparam int NUM_CNT   = 4;
  localparam int IDX_SG_RD = 0;
  localparam int IDX_SG_WR = 1;
  localparam int IDX_BS_RD = 2;
  localparam int IDX_BS_WR = 3;

  typedef enum logic [3:0] {
    EV_IDLE,
    EV_SGL_RD,
    EV_SGL_WR,
    EV_BEAT,
    EV_END_RD,
    EV_END_WR,
    EV_ERR_MIX,
    EV_ERR_LEN,
    EV_ERR_UNK
  } beat_ev_t;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_MIX  = 2'd1,
    CAUSE_LEN  = 2'd2,
    CAUSE_UNK  = 2'd3
  } err_cause_t;

  function automatic err_cause_t cause_of(beat_ev_t ev);
    case (ev)
      EV_ERR_MIX: return CAUSE_MIX;
      EV_ERR_LEN: return CAUSE_LEN;
      EV_ERR_UNK: return CAUSE_UNK;
      default:    return CAUSE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/cti_beat_classifier.sv
module cti_beat_classifier
  import cti_mon_pkg::*;
(
  input  logic       cyc,
  input  logic       we,
  input  logic       ack,
  input  logic [2:0] cti,
  input  logic       burst_open,
  input  logic       at_last,
  output beat_ev_t   ev
);

  always_comb begin
    ev = EV_IDLE;
    if (ack) begin
      if (!cyc) begin
        ev = EV_ERR_UNK;
      end else begin
        case (cti)
          CTI_CLASSIC: ev = burst_open ? EV_ERR_MIX : (we ? EV_SGL_WR : EV_SGL_RD);
          CTI_INCR:    ev = at_last ? EV_ERR_LEN : EV_BEAT;
          CTI_LAST:    ev = at_last ? (we ? EV_END_WR : EV_END_RD) : EV_ERR_LEN;
          default:     ev = EV_ERR_UNK;
        endcase
      end
    end
  end

endmodule

// File: rtl/cti_beat_tracker.sv
module cti_beat_tracker
  import cti_mon_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  beat_ev_t ev,
  output logic     burst_open,
  output logic     at_last
);

  localparam int BEAT_W = $clog2(BURST_LEN);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BURST_LEN - 1);

  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
    end else begin
      case (ev)
        EV_BEAT:                          beat_q <= beat_q + 1'b1;
        EV_END_RD, EV_END_WR, EV_ERR_LEN: beat_q <= '0;
        default:                          beat_q <= beat_q;
      endcase
    end
  end

  assign burst_open = (beat_q != '0);
  assign at_last    = (beat_q == LAST);

  p_beat_bound_r6: assert property (@(posedge clk) disable iff (rst)
    beat_q <= LAST);

  p_close_after_end_r4: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_END_RD || ev == EV_END_WR || ev == EV_ERR_LEN) |=> !burst_open);

  p_no_ack_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_IDLE) |=> $stable(beat_q));

endmodule

// File: rtl/cti_sat_counter.sv
module cti_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (inc && count != MAXV)
      count <= count + 1'b1;
  end

  p_saturate_r9: assert property (@(posedge clk) disable iff (rst)
    (count == MAXV) |=> (count == MAXV));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (inc && count != MAXV) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/burst_cti_monitor.sv
module burst_cti_monitor
  import cti_mon_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_cyc,
  input  logic             bus_we,
  input  logic             bus_ack,
  input  logic [2:0]       bus_cti,
  output logic [CNT_W-1:0] single_rd_count,
  output logic [CNT_W-1:0] single_wr_count,
  output logic [CNT_W-1:0] burst_rd_count,
  output logic [CNT_W-1:0] burst_wr_count,
  output logic             err_flag,
  output logic [1:0]       err_cause
);

  beat_ev_t         ev;
  logic             burst_open;
  logic             at_last;
  logic [NUM_CNT-1:0] inc;
  logic [CNT_W-1:0] cnt [NUM_CNT];
  err_cause_t       cause_q;

  cti_beat_classifier u_class (
    .cyc        (bus_cyc),
    .we         (bus_we),
    .ack        (bus_ack),
    .cti        (bus_cti),
    .burst_open (burst_open),
    .at_last    (at_last),
    .ev         (ev)
  );

  cti_beat_tracker #(.BURST_LEN(BURST_LEN)) u_track (
    .clk        (clk),
    .rst        (rst),
    .ev         (ev),
    .burst_open (burst_open),
    .at_last    (at_last)
  );

  always_comb begin
    inc            = '0;
    inc[IDX_SG_RD] = (ev == EV_SGL_RD);
    inc[IDX_SG_WR] = (ev == EV_SGL_WR);
    inc[IDX_BS_RD] = (ev == EV_END_RD);
    inc[IDX_BS_WR] = (ev == EV_END_WR);
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    cti_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (inc[g]),
      .count (cnt[g])
    );
  end

  assign single_rd_count = cnt[IDX_SG_RD];
  assign single_wr_count = cnt[IDX_SG_WR];
  assign burst_rd_count  = cnt[IDX_BS_RD];
  assign burst_wr_count  = cnt[IDX_BS_WR];

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag <= 1'b0;
      cause_q  <= CAUSE_NONE;
    end else if (!err_flag && cause_of(ev) != CAUSE_NONE) begin
      err_flag <= 1'b1;
      cause_q  <= cause_of(ev);
    end
  end

  assign err_cause = cause_q;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (single_rd_count == '0 && single_wr_count == '0 &&
             burst_rd_count == '0 && burst_wr_count == '0 && !err_flag && err_cause == 2'd0));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !bus_ack |=> ($stable(single_rd_count) && $stable(single_wr_count) &&
                  $stable(burst_rd_count) && $stable(burst_wr_count) && $stable(err_flag)));

  p_mix_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_ack && bus_cyc && bus_cti == 3'b000 && burst_open && !err_flag) |=> (err_cause == 2'd1));

  p_unknown_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_ack && !bus_cyc && !err_flag) |=> (err_flag && err_cause == 2'd3));

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> (err_flag && $stable(err_cause)));

endmodule

// File: tb/tb_burst_cti_monitor.sv
module tb_burst_cti_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int BL         = 4;
  localparam int CW         = 16;
  localparam int CMAX       = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_cyc = 1'b0, bus_we = 1'b0, bus_ack = 1'b0;
  logic [2:0]    bus_cti = 3'b000;
  logic [CW-1:0] srd, swr, brd, bwr;
  logic          eflag;
  logic [1:0]    ecause;

  int n_chk = 0;
  int n_bad = 0;

  // behavioural reference state
  int m_srd = 0, m_swr = 0, m_brd = 0, m_bwr = 0, m_beats = 0, m_flag = 0, m_cause = 0;

  burst_cti_monitor #(.BURST_LEN(BL), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_ack(bus_ack),
    .bus_cti(bus_cti), .single_rd_count(srd), .single_wr_count(swr),
    .burst_rd_count(brd), .burst_wr_count(bwr), .err_flag(eflag), .err_cause(ecause)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int bump(int v);
    return (v >= CMAX) ? CMAX : v + 1;
  endfunction

  task automatic m_err(int c);
    if (m_flag == 0) begin
      m_flag  = 1;
      m_cause = c;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_srd = 0; m_swr = 0; m_brd = 0; m_bwr = 0; m_beats = 0; m_flag = 0; m_cause = 0;
    end else if (bus_ack) begin
      if (!bus_cyc) m_err(3);
      else if (bus_cti == 3'b000) begin
        if (m_beats != 0) m_err(1);
        else if (bus_we) m_swr = bump(m_swr);
        else m_srd = bump(m_srd);
      end else if (bus_cti == 3'b010) begin
        if (m_beats == BL - 1) begin m_err(2); m_beats = 0; end
        else m_beats++;
      end else if (bus_cti == 3'b111) begin
        if (m_beats == BL - 1) begin
          if (bus_we) m_bwr = bump(m_bwr); else m_brd = bump(m_brd);
        end else m_err(2);
        m_beats = 0;
      end else m_err(3);
    end
  end

  task automatic check(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    check("R2", int'(srd), m_srd, "single_rd_count");
    check("R2", int'(swr), m_swr, "single_wr_count");
    check("R4", int'(brd), m_brd, "burst_rd_count");
    check("R4", int'(bwr), m_bwr, "burst_wr_count");
    check("R8", int'(eflag), m_flag, "err_flag");
    check("R8", int'(ecause), m_cause, "err_cause");
  end

  task automatic beat(logic c, logic w, logic a, logic [2:0] t);
    @(negedge clk);
    bus_cyc = c; bus_we = w; bus_ack = a; bus_cti = t;
  endtask

  task automatic settle();
    @(negedge clk);
    bus_ack = 1'b0; bus_cyc = 1'b0; bus_cti = 3'b000;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_ack = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic burst(logic w, int nbeats);
    for (int i = 0; i < nbeats; i++) beat(1'b1, w, 1'b1, 3'b010);
    beat(1'b1, w, 1'b1, 3'b111);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    settle();
    check("R1", int'(srd) + int'(swr) + int'(brd) + int'(bwr), 0, "counters after reset");
    check("R1", int'(eflag), 0, "err_flag after reset");

    // singles in both directions
    beat(1, 1, 1, 3'b000); beat(1, 1, 1, 3'b000); beat(1, 0, 1, 3'b000);
    beat(1, 1, 1, 3'b000); beat(1, 0, 1, 3'b000);
    settle();
    check("R2", int'(swr), 3, "single writes");
    check("R2", int'(srd), 2, "single reads");

    // ack low with junk on the other lines
    beat(1, 1, 0, 3'b000); beat(0, 0, 0, 3'b101); beat(1, 0, 0, 3'b111); beat(1, 1, 0, 3'b010);
    settle();
    check("R3", int'(swr) + int'(srd) + int'(brd) + int'(bwr), 5, "no change without ack");
    check("R3", int'(eflag), 0, "no error without ack");

    // legal bursts, one with idle gaps inside
    burst(1, BL - 1);
    burst(0, BL - 1);
    beat(1, 0, 1, 3'b010); beat(1, 0, 0, 3'b000); beat(1, 0, 1, 3'b010);
    beat(0, 0, 0, 3'b000); beat(1, 0, 1, 3'b010); beat(1, 0, 1, 3'b111);
    settle();
    check("R4", int'(bwr), 1, "write bursts");
    check("R4", int'(brd), 2, "read bursts incl. gapped");
    check("R4", int'(eflag), 0, "legal bursts raise no error");

    // short burst
    burst(1, 1);
    settle();
    check("R6", int'(ecause), 2, "short burst cause");
    check("R6", int'(bwr), 1, "short burst not counted");
    beat(1, 0, 1, 3'b000);
    settle();
    check("R8", int'(srd), 3, "counting continues after error");
    check("R6", int'(eflag), 1, "burst closed, flag stays");

    // single inside burst, then a later different error
    do_reset();
    beat(1, 1, 1, 3'b010); beat(1, 1, 1, 3'b000);
    settle();
    check("R5", int'(ecause), 1, "single inside burst cause");
    check("R5", int'(swr), 0, "mixed single not counted");
    beat(1, 1, 1, 3'b001);
    settle();
    check("R8", int'(ecause), 1, "first cause kept");

    // over-long burst
    do_reset();
    burst(1, BL);
    settle();
    check("R6", int'(ecause), 2, "long burst cause");
    check("R6", int'(bwr), 0, "long burst not counted");

    // unknown: cyc low, then reserved type
    do_reset();
    beat(0, 0, 1, 3'b000);
    settle();
    check("R7", int'(ecause), 3, "ack without cyc");
    do_reset();
    beat(1, 0, 1, 3'b100);
    settle();
    check("R7", int'(ecause), 3, "reserved cycle type");

    // reset clears a sticky error
    do_reset();
    settle();
    check("R1", int'(eflag), 0, "reset clears sticky flag");
    check("R1", int'(ecause), 0, "reset clears cause");

    // saturation
    for (int i = 0; i < CMAX + 5; i++) beat(1, 1, 1, 3'b000);
    settle();
    check("R9", int'(swr), CMAX, "write single counter saturates");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule